// File: doc/BRIEF.md
# Array write-protection register and address guard

This block keeps the write-protection setting of a serial EEPROM slave and answers, for any array address, whether a write there must be refused. The protocol engine reports the data bytes of each write transaction, and it reports the stop condition that would start an internal write cycle. When a transaction targets register space, meaning address bit 15 is set, the block takes a single data byte as the new setting. It also serves register reads for that engine.

The setting has three parts: an enable flag, a 2-bit size code that protects the top 1/4, 1/2, 3/4 or all of an 8 KB array, and a lock flag. Once the lock flag is set, the setting can no longer change. The page-write logic uses the combinational `prot_hit` output to drop protected bytes. Array reads do not pass through this block, so protection never holds them back. Register reads are refused while an internal write cycle is running.

Top module: `wp_guard`

## Requirements
- R1: After reset the setting is 00h: a register read returns 00h and `prot_hit` is 0 for every address.
- R2: With setting bit 3 at 0, `prot_hit` is 0 for every array address, whatever bits 2:1 hold.
- R3: With bit 3 at 1, the size code in bits 2:1 picks the protected array addresses, taken from address bits 12:0: 00 protects 1800h and up, 01 protects 1000h and up, 10 protects 0800h and up, and 11 protects the whole array. Address bits 14:13 are ignored.
- R4: Once setting bit 0 (lock) is 1, a later register write changes no bit of the setting.
- R5: Data bits 7:4 are discarded on write, and register reads return 0 in bits 7:4.
- R6: A write transaction that carries two or more data bytes to register space leaves the setting unchanged.
- R7: A write takes effect only on the commit pulse. The register is selected by address bit 15 alone, with every other address bit ignored. A single-byte write with bit 15 at 0 leaves the setting alone.
- R8: A register read request is answered in the next cycle with `rd_ack` at 1 and the setting on `rd_data`. A read request with bit 15 at 0 gives `rd_ack` at 0.
- R9: A continued read (`rd_cont` at 1) keeps the space chosen by the first read of the sequence, so a register sequence returns the setting again even when the address has wrapped below 8000h.
- R10: A read request made while `busy` is 1 is answered with `rd_ack` at 0 and `rd_data` at 00h.
- R11: `prot_hit` is 0 for any `chk_addr` with bit 15 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| busy | input | 1 | Internal write cycle in progress |
| wr_open | input | 1 | Pulse: a write transaction begins, clears byte tracking |
| wr_byte_vld | input | 1 | A data byte of the write transaction is present |
| wr_addr | input | 16 | Address that the data byte targets |
| wr_byte | input | 8 | Data byte |
| wr_commit | input | 1 | Pulse: stop in the slot that starts a write cycle |
| rd_req | input | 1 | Read request |
| rd_cont | input | 1 | Request continues the current sequential read |
| rd_addr | input | 16 | Read address |
| rd_ack | output | 1 | Register read accepted, data valid |
| rd_data | output | 8 | Register read data |
| chk_addr | input | 16 | Address under protection check |
| prot_hit | output | 1 | Write to `chk_addr` must be refused |

## Verification
`prot_hit` is combinational from `chk_addr` and the stored setting. A new setting is in place after the clock edge that samples `wr_commit`, so the bench checks it one nanosecond after that edge. The read reply is registered and stays valid for exactly the one cycle after the edge that samples `rd_req`. The bench drives on falling edges and samples each reply 1 ns after the next rising edge. The setting itself is seen only through those reads and `prot_hit` sweeps, compared against a bench model updated at each commit.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int AW      = 16,
  parameter int ARR_W   = 13,
  parameter int SEL_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          wr_open,
  input  logic          wr_byte_vld,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_byte,
  input  logic          wr_commit,
  input  logic          rd_req,
  input  logic          rd_cont,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ack,
  output logic [7:0]    rd_data,
  input  logic [AW-1:0] chk_addr,
  output logic          prot_hit
);
  logic [3:0] wp_q;
  logic [3:0] stg_q;
  logic [1:0] cnt_q;
  logic       tgt_q;
  logic       mode_q;
  logic       ack_q;
  logic [7:0] data_q;
  logic       rd_sel;
  logic [1:0] top2;
  logic       unused_bits;

  assign unused_bits = ^{wr_addr, rd_addr, chk_addr, wr_byte[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      stg_q <= '0;
      cnt_q <= '0;
      tgt_q <= 1'b0;
    end else if (wr_commit) begin
      if (tgt_q && cnt_q == 2'd1 && !wp_q[0]) wp_q <= stg_q;
      cnt_q <= '0;
      tgt_q <= 1'b0;
    end else if (wr_open) begin
      cnt_q <= '0;
      tgt_q <= 1'b0;
    end else if (wr_byte_vld) begin
      if (cnt_q == 2'd0) begin
        tgt_q <= wr_addr[SEL_BIT];
        stg_q <= wr_byte[3:0];
      end
      if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
    end
  end

  assign rd_sel = rd_cont ? mode_q : rd_addr[SEL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      ack_q <= rd_req & rd_sel & ~busy;
      if (rd_req) begin
        mode_q <= rd_sel;
        data_q <= (rd_sel & ~busy) ? {4'b0000, wp_q} : 8'h00;
      end
    end
  end

  assign rd_ack  = ack_q;
  assign rd_data = data_q;

  assign top2     = chk_addr[ARR_W-1 -: 2];
  assign prot_hit = ~chk_addr[SEL_BIT] & wp_q[3] & (top2 >= ~wp_q[2:1]);
endmodule

module wp_guard_chk #(
  parameter int AW = 16,
  parameter int SEL_BIT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [7:0]    rd_data,
  input logic          wr_commit,
  input logic [3:0]    wp_q,
  input logic [AW-1:0] chk_addr,
  input logic          prot_hit
);
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q[0] |=> wp_q[0]);
  a_r4_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q[0] |=> $stable(wp_q));
  a_r7_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(wp_q));
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:4] == 4'h0);
  a_r10_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && busy) |=> (!rd_ack && rd_data == 8'h00));
  a_r8_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_ack);
  a_r11_reg_space_clear: assert property (@(posedge clk) disable iff (!rst_n)
    chk_addr[SEL_BIT] |-> !prot_hit);
endmodule

bind wp_guard wp_guard_chk #(.AW(AW), .SEL_BIT(SEL_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_ack(rd_ack),
  .rd_data(rd_data), .wr_commit(wr_commit), .wp_q(wp_q),
  .chk_addr(chk_addr), .prot_hit(prot_hit)
);

// File: tb/wp_guard_tb_top.sv
`timescale 1ns/1ps
module wp_guard_tb_top;
  logic clk = 0, rst_n = 0, busy = 0;
  logic wr_open = 0, wr_byte_vld = 0, wr_commit = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0, chk_addr = 0;
  logic [7:0] wr_byte = 0;
  logic rd_req = 0, rd_cont = 0;
  logic rd_ack, prot_hit;
  logic [7:0] rd_data;
  int nchk = 0, nerr = 0;
  logic [3:0] m_reg = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wp_guard dut_i (.clk(clk), .rst_n(rst_n), .busy(busy), .wr_open(wr_open),
    .wr_byte_vld(wr_byte_vld), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .wr_commit(wr_commit), .rd_req(rd_req), .rd_cont(rd_cont), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .chk_addr(chk_addr), .prot_hit(prot_hit));

  function automatic bit exp_hit(logic [15:0] a, logic [3:0] r);
    if (a[15] || !r[3]) return 0;
    return a[12:11] >= (2'd3 - r[2:1]);
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; m_reg = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic do_write(logic [15:0] a, int n, logic [7:0] d0, logic [7:0] d1, bit commit);
    @(negedge clk); wr_open = 1;
    @(negedge clk); wr_open = 0;
    for (int i = 0; i < n; i++) begin
      wr_byte_vld = 1; wr_addr = a + 16'(i); wr_byte = (i == 0) ? d0 : d1;
      @(negedge clk);
    end
    wr_byte_vld = 0;
    if (commit) begin
      wr_commit = 1;
      @(negedge clk); wr_commit = 0;
      if (n == 1 && a[15] && !m_reg[0]) m_reg = d0[3:0];
    end
  endtask

  task automatic do_read(logic [15:0] a, bit cont, bit exp_ack, logic [7:0] exp_d, string req);
    @(negedge clk); rd_req = 1; rd_cont = cont; rd_addr = a;
    @(posedge clk); #1;
    check(rd_ack === exp_ack, req, {15'd0, rd_ack}, {15'd0, exp_ack});
    check(rd_data === exp_d, req, {8'd0, rd_data}, {8'd0, exp_d});
    @(negedge clk); rd_req = 0; rd_cont = 0;
  endtask

  task automatic read_reg(string req);
    do_read(16'h8000, 0, 1, {4'h0, m_reg}, req);
  endtask

  task automatic probe(logic [15:0] a, string req);
    @(negedge clk); chk_addr = a; #1;
    check(prot_hit === exp_hit(a, m_reg), req, {15'd0, prot_hit}, {15'd0, exp_hit(a, m_reg)});
  endtask

  task automatic sweep(string req);
    foreach (sweep_pts[i]) probe(sweep_pts[i], req);
  endtask

  logic [15:0] sweep_pts [8] = '{16'h0000, 16'h07FF, 16'h0800, 16'h0FFF,
                                 16'h1000, 16'h17FF, 16'h1800, 16'h7FFF};

  initial begin
    #400000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    read_reg("R1 reset value");
    sweep("R1 no protection after reset");
    // R2: size code set but enable clear
    do_write(16'h8000, 1, 8'h06, 8'h00, 1);
    sweep("R2 disabled");
    // R3: each size code
    for (int s = 0; s < 4; s++) begin
      do_write(16'hC123, 1, 8'(8 | (s << 1)), 8'h00, 1);
      read_reg("R7 any address with bit15");
      sweep("R3 size code");
      probe(16'h7800, "R3 bits 14:13 ignored");
      probe(16'h9FFF, "R11 register space");
    end
    // R5: upper bits dropped
    do_write(16'hFFFF, 1, 8'hFA, 8'h00, 1);
    read_reg("R5 upper bits read zero");
    // R6: two bytes cancel
    do_write(16'h8000, 2, 8'h0C, 8'h0C, 1);
    read_reg("R6 multi-byte cancels");
    // R7: no commit, and array address
    do_write(16'h8000, 1, 8'h04, 8'h00, 0);
    read_reg("R7 no commit");
    do_write(16'h1000, 1, 8'h04, 8'h00, 1);
    read_reg("R7 array write ignored");
    // R8: array read not acknowledged
    do_read(16'h1234, 0, 0, 8'h00, "R8 array read no ack");
    // R9: sequential register read wraps
    do_read(16'hFFFF, 0, 1, {4'h0, m_reg}, "R9 first");
    do_read(16'h0000, 1, 1, {4'h0, m_reg}, "R9 continued after wrap");
    do_read(16'h0001, 1, 1, {4'h0, m_reg}, "R9 continued again");
    // R10: busy refuses
    @(negedge clk); busy = 1;
    do_read(16'h8000, 0, 0, 8'h00, "R10 busy");
    busy = 0;
    // R4: lock
    do_write(16'h8000, 1, 8'h0B, 8'h00, 1);
    read_reg("R4 lock set");
    do_write(16'h8000, 1, 8'h00, 8'h00, 1);
    read_reg("R4 locked write ignored");
    sweep("R4 protection frozen");
    // random phase
    for (int k = 0; k < 300; k++) begin
      int op;
      if (k % 25 == 0) do_reset();
      op = int'($urandom_range(0, 3));
      case (op)
        0, 1: begin
          logic [7:0] d;
          d = 8'($urandom);
          if ($urandom_range(0, 7) != 0) d[0] = 0;
          do_write({1'($urandom_range(0, 1)), 15'($urandom)},
                   int'($urandom_range(1, 2)), d, 8'($urandom), 1);
        end
        2: read_reg("R8 random read");
        default: probe(16'($urandom), "R3 random probe");
      endcase
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule